// File: doc/BRIEF.md
# Piecewise-Linear Base-2 Logarithm Converter

This block turns a 16-bit unsigned integer into an approximate base-2 logarithm with a 4-bit integer part and a 13-bit fraction. The integer part is the position of the highest set input bit. The bits below that one are packed, left-justified, into a 13-bit mantissa fraction x in [0, 1). The fraction of the result approximates log2(1+x) in three steps:

1. One of four straight-line pieces is chosen by the top two bits of x.
2. That piece is built only from right shifts of x, one add or subtract, and a fixed offset.
3. A signed correction is added from a 128-entry table of 5-bit values, indexed by the top seven bits of x.

The table contents are derived at elaboration from the ideal curve, so no constants are typed in by hand.

The datapath is purely combinational. A parameter puts a result register on the outputs, and that register gives one cycle of latency together with a valid flag. An input of zero has no logarithm, so it is reported on a separate flag with all-zero result fields. Typical users are hybrid linear/log arithmetic units, where products become sums and roots become shifts.

Top module: `log2_pwl_conv`

## Requirements
- R1: For a nonzero input, `k_out` equals the bit index of the most significant set bit of `n_in` (0 for an input of 1, 15 for inputs of 0x8000 and above).
- R2: When the input is an exact power of two, `f_out` is 0, so the result is the exact integer logarithm.
- R3: An input of 0 gives `zero_out` = 1 with `k_out` = 0 and `f_out` = 0. Any nonzero input gives `zero_out` = 0.
- R4: For every nonzero input, |k_out + f_out·2^-13 − log2(n_in)| ≤ 20·2^-13.
- R5: The fraction is built from the linear pieces, selected by x[12:11]: 00 → x + x/4 + 2^-7, 01 → x + x/16 + 2^-4, 10 → x − x/8 + 77·2^-9, 11 → x/2 + x/4 + 1/4. A signed 5-bit correction with an LSB weight of 2^-10 is then added, indexed by x[12:6]. The sum is clamped to [0, 1 − 2^-13]. The accuracy bound of R4 holds at every piece and table-interval boundary.
- R6: With the output register on (the default), `valid_out` equals `valid_in` from the previous rising edge, and the result for an input accepted with `valid_in` = 1 appears after that edge.
- R7: While `valid_in` is 0, `k_out`, `f_out` and `zero_out` keep the values they had.
- R8: After synchronous reset, `valid_out`, `k_out`, `f_out` and `zero_out` are all 0.
- R9: When the leading one is above bit 13, input bits that do not fit in the 13-bit fraction are dropped. For example, 0xC000 and 0xC003 give identical outputs, and so do 0x4000 and 0x4001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional result register |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Input sample is valid and is captured |
| n_in | input | 16 | Unsigned integer operand |
| valid_out | output | 1 | Result fields hold a new result |
| k_out | output | 4 | Integer part of the logarithm |
| f_out | output | 13 | Fraction part of the logarithm, weight 2^-13 per LSB |
| zero_out | output | 1 | Operand was zero; result fields are 0 |

## Verification
Every possible operand is driven and compared against a real-valued logarithm. This means a wrong piece slope, a misplaced offset, or a correction table that is shifted, mis-signed or indexed from the wrong bits shows up as errors of several thousandths, far beyond the bound. Directed operands sit on the piece and table-interval edges. These expose an off-by-one in the segment select or a missing clamp, which would give a fraction that wraps near 1.0 or goes negative near 0. Powers of two and the zero operand catch a design that lets the correction leak into exact results or reports a logarithm for zero. Hold stretches with `valid_in` low, and operand pairs that differ only in dropped low bits, catch a register that loads every cycle and a normalizer that keeps bits it should discard.

// File: rtl/log2pwl_pkg.sv
package log2pwl_pkg;

    // Fixed-point precision used when building the correction table
    localparam int TBL_Q = 22;
    // Internal precision of the squaring log routine
    localparam int SQ_Q = 28;

    typedef enum logic [1:0] {
        SEG_LOW   = 2'd0,
        SEG_MIDLO = 2'd1,
        SEG_MIDHI = 2'd2,
        SEG_HIGH  = 2'd3
    } seg_e;

    // Offset of each linear piece on a grid with frac_w fraction bits
    function automatic longint seg_offset(int seg, int frac_w);
        case (seg)
            0:       return longint'(1) <<< (frac_w - 7);
            1:       return longint'(1) <<< (frac_w - 4);
            2:       return longint'(77) <<< (frac_w - 9);
            default: return longint'(1) <<< (frac_w - 2);
        endcase
    endfunction

    // Linear piece evaluated at x = j / 2^idx_w, result in Q.TBL_Q
    function automatic longint lin_q(longint j, int seg, int idx_w);
        longint x;
        x = j <<< (TBL_Q - idx_w);
        case (seg)
            0:       return x + (x >>> 2) + seg_offset(0, TBL_Q);
            1:       return x + (x >>> 4) + seg_offset(1, TBL_Q);
            2:       return x - (x >>> 3) + seg_offset(2, TBL_Q);
            default: return (x >>> 1) + (x >>> 2) + seg_offset(3, TBL_Q);
        endcase
    endfunction

    // log2(1 + j / 2^idx_w) in Q.TBL_Q by repeated squaring
    function automatic longint log1p_q(longint j, int idx_w);
        longint unsigned y;
        longint r;
        y = longint'((longint'(1) <<< idx_w) + j) << (SQ_Q - idx_w);
        r = 0;
        for (int b = TBL_Q - 1; b >= 0; b--) begin
            y = (y * y) >> SQ_Q;
            if (y >= (longint'(2) << SQ_Q)) begin
                r = r | (longint'(1) <<< b);
                y = y >> 1;
            end
        end
        return r;
    endfunction

    // Correction for interval i: mean of the endpoint errors, rounded to 2^-lsb_exp
    function automatic int corr_entry(int i, int idx_w, int lsb_exp, int corr_w);
        int     seg;
        int     sh;
        longint e2;
        longint v;
        longint hi;
        longint lo;
        seg = i >> (idx_w - 2);
        e2  = log1p_q(longint'(i), idx_w) + log1p_q(longint'(i + 1), idx_w)
            - lin_q(longint'(i), seg, idx_w) - lin_q(longint'(i + 1), seg, idx_w);
        sh  = TBL_Q - lsb_exp + 1;
        v   = (e2 + (longint'(1) <<< (sh - 1))) >>> sh;
        hi  = (longint'(1) <<< (corr_w - 1)) - 1;
        lo  = -hi - 1;
        if (v > hi) v = hi;
        if (v < lo) v = lo;
        return int'(v);
    endfunction

endpackage

// File: rtl/l2c_normalize.sv
module l2c_normalize #(
    parameter int IN_W   = 16,
    parameter int FRAC_W = 13,
    localparam int K_W   = $clog2(IN_W)
) (
    input  logic [IN_W-1:0]   n,
    output logic [K_W-1:0]    k,
    output logic [FRAC_W-1:0] x,
    output logic              is_zero
);
    // Leading-one position: the highest set bit wins
    always_comb begin
        k = '0;
        for (int i = 0; i < IN_W; i++) begin
            if (n[i]) k = i[K_W-1:0];
        end
    end

    assign is_zero = (n == '0);

    // Bits below the leading one, left-justified; missing bits become zero
    always_comb begin
        for (int b = 0; b < FRAC_W; b++) begin
            int src;
            src = int'(k) - 1 - b;
            x[FRAC_W-1-b] = (src >= 0) ? n[src[K_W-1:0]] : 1'b0;
        end
    end

    // R1: the reported position holds a one and nothing above it is set
    always_comb begin
        if (!is_zero) begin
            assert_lead_one_R1: assert (n[k] == 1'b1 && (n >> k) == IN_W'(1));
        end
    end

    // R2: a power-of-two operand leaves an empty fraction
    always_comb begin
        if (!is_zero && ((n & (n - IN_W'(1))) == '0)) begin
            assert_pow2_frac_R2: assert (x == '0);
        end
    end

endmodule

// File: rtl/l2c_segment.sv
module l2c_segment
    import log2pwl_pkg::*;
#(
    parameter int FRAC_W = 13
) (
    input  logic [FRAC_W-1:0] x,
    output logic [FRAC_W:0]   lin
);
    localparam logic [FRAC_W:0] OFF_LOW   = (FRAC_W+1)'(seg_offset(0, FRAC_W));
    localparam logic [FRAC_W:0] OFF_MIDLO = (FRAC_W+1)'(seg_offset(1, FRAC_W));
    localparam logic [FRAC_W:0] OFF_MIDHI = (FRAC_W+1)'(seg_offset(2, FRAC_W));
    localparam logic [FRAC_W:0] OFF_HIGH  = (FRAC_W+1)'(seg_offset(3, FRAC_W));

    seg_e            seg;
    logic [FRAC_W:0] xe;

    assign seg = seg_e'(x[FRAC_W-1 -: 2]);
    assign xe  = {1'b0, x};

    // Slopes from right shifts and one add or subtract per piece
    always_comb begin
        unique case (seg)
            SEG_LOW:   lin = xe + (xe >> 2) + OFF_LOW;
            SEG_MIDLO: lin = xe + (xe >> 4) + OFF_MIDLO;
            SEG_MIDHI: lin = xe - (xe >> 3) + OFF_MIDHI;
            default:   lin = (xe >> 1) + (xe >> 2) + OFF_HIGH;
        endcase
    end

    // R5: the linear estimate stays below 1.0 on every piece
    always_comb begin
        assert_lin_range_R5: assert (lin < ((FRAC_W+1)'(1) << FRAC_W));
    end

endmodule

// File: rtl/l2c_corr_rom.sv
module l2c_corr_rom
    import log2pwl_pkg::*;
#(
    parameter int IDX_W   = 7,
    parameter int CORR_W  = 5,
    parameter int LSB_EXP = 10,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic [IDX_W-1:0]         idx,
    output logic signed [CORR_W-1:0] corr
);
    logic signed [CORR_W-1:0] tbl [ENTRIES];

    // Each entry is derived from the ideal curve at elaboration
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        localparam int VAL = corr_entry(i, IDX_W, LSB_EXP, CORR_W);
        assign tbl[i] = CORR_W'(VAL);
    end

    assign corr = tbl[idx];

endmodule

// File: rtl/log2_pwl_conv.sv
module log2_pwl_conv #(
    parameter int IN_W    = 16,
    parameter int FRAC_W  = 13,
    parameter int IDX_W   = 7,
    parameter int CORR_W  = 5,
    parameter int LSB_EXP = 10,
    parameter bit REG_OUT = 1'b1,
    localparam int K_W    = $clog2(IN_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_in,
    input  logic [IN_W-1:0]   n_in,
    output logic              valid_out,
    output logic [K_W-1:0]    k_out,
    output logic [FRAC_W-1:0] f_out,
    output logic              zero_out
);
    localparam int SUM_W      = FRAC_W + 2;
    localparam int CORR_SHIFT = FRAC_W - LSB_EXP;
    localparam logic signed [SUM_W-1:0] F_MAX = SUM_W'((1 << FRAC_W) - 1);

    logic [K_W-1:0]           k_c;
    logic [FRAC_W-1:0]        x_c;
    logic                     zero_c;
    logic [FRAC_W:0]          lin_c;
    logic signed [CORR_W-1:0] corr_c;
    logic signed [SUM_W-1:0]  sum_c;
    logic [FRAC_W-1:0]        f_c;
    logic [K_W-1:0]           k_res;
    logic [FRAC_W-1:0]        f_res;

    l2c_normalize #(.IN_W(IN_W), .FRAC_W(FRAC_W)) u_norm (
        .n(n_in), .k(k_c), .x(x_c), .is_zero(zero_c)
    );

    l2c_segment #(.FRAC_W(FRAC_W)) u_seg (
        .x(x_c), .lin(lin_c)
    );

    l2c_corr_rom #(.IDX_W(IDX_W), .CORR_W(CORR_W), .LSB_EXP(LSB_EXP)) u_rom (
        .idx(x_c[FRAC_W-1 -: IDX_W]), .corr(corr_c)
    );

    // Linear estimate plus scaled correction, clamped to the fraction range
    always_comb begin
        sum_c = $signed({1'b0, lin_c})
              + ($signed({{(SUM_W-CORR_W){corr_c[CORR_W-1]}}, corr_c}) <<< CORR_SHIFT);
        if (sum_c < 0)          f_c = '0;
        else if (sum_c > F_MAX) f_c = '1;
        else                    f_c = sum_c[FRAC_W-1:0];
    end

    // Zero operand and exact powers of two bypass the approximation
    always_comb begin
        k_res = k_c;
        f_res = f_c;
        if (zero_c) begin
            k_res = '0;
            f_res = '0;
        end else if (x_c == '0) begin
            f_res = '0;
        end
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_out <= 1'b0;
                k_out     <= '0;
                f_out     <= '0;
                zero_out  <= 1'b0;
            end else begin
                valid_out <= valid_in;
                if (valid_in) begin
                    k_out    <= k_res;
                    f_out    <= f_res;
                    zero_out <= zero_c;
                end
            end
        end

        assert_valid_lat_R6: assert property (@(posedge clk) disable iff (rst)
            $past(!rst) |-> (valid_out == $past(valid_in)));

        assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst) && !$past(valid_in)) |->
                ($stable(k_out) && $stable(f_out) && $stable(zero_out)));

        assert_zero_clean_R3: assert property (@(posedge clk) disable iff (rst)
            zero_out |-> (k_out == '0 && f_out == '0));
    end else begin : g_comb
        assign valid_out = valid_in;
        assign k_out     = k_res;
        assign f_out     = f_res;
        assign zero_out  = zero_c;
    end

endmodule

// File: tb/tb_log2_pwl_conv.sv
module tb_log2_pwl_conv;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;
    localparam real TOL       = 20.0 / 8192.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_in = 1'b0;
    logic [15:0] n_in = '0;
    logic        valid_out;
    logic [3:0]  k_out;
    logic [12:0] f_out;
    logic        zero_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Inputs applied at the previous step and the last accepted operand
    int pend_n = 0;
    bit pend_v = 1'b0;
    bit have_held = 1'b0;
    int last_k = 0, last_f = 0, prev_k = 0, prev_f = 0;

    log2_pwl_conv dut (
        .clk(clk), .rst(rst), .valid_in(valid_in), .n_in(n_in),
        .valid_out(valid_out), .k_out(k_out), .f_out(f_out), .zero_out(zero_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(bit ok, string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s", msg);
        end
    endtask

    function automatic int exp_k(int n);
        int r = 0;
        for (int i = 0; i < 16; i++) if (n[i]) r = i;
        return r;
    endfunction

    task automatic check_result(int n, string tag);
        real got, ideal;
        if (n == 0) begin
            chk(zero_out == 1'b1 && k_out == 0 && f_out == 0,
                $sformatf("R3 zero operand: zf=%0d k=%0d f=%0d expected zf=1 k=0 f=0",
                          zero_out, k_out, f_out));
            return;
        end
        chk(k_out == 4'(exp_k(n)),
            $sformatf("R1 n=%0h k=%0d expected %0d", n, k_out, exp_k(n)));
        chk(zero_out == 1'b0,
            $sformatf("R3 n=%0h zf=%0d expected 0", n, zero_out));
        got   = real'(k_out) + real'(f_out) / 8192.0;
        ideal = $ln(real'(n)) / $ln(2.0);
        chk((got - ideal) <= TOL && (ideal - got) <= TOL,
            $sformatf("%s n=%0h result=%f expected %f", tag, n, got, ideal));
        if ((n & (n - 1)) == 0)
            chk(f_out == 0, $sformatf("R2 n=%0h f=%0d expected 0", n, f_out));
    endtask

    // One clock per call: check what the previous call's inputs produced, then apply new ones
    task automatic step(int n, bit v, string tag = "R4");
        @(negedge clk);
        chk(valid_out == pend_v,
            $sformatf("R6 valid_out=%0d expected %0d", valid_out, pend_v));
        if (pend_v) begin
            have_held = 1'b1;
            prev_k = last_k; prev_f = last_f;
            last_k = int'(k_out); last_f = int'(f_out);
            check_result(pend_n, tag);
        end else if (have_held) begin
            chk(int'(k_out) == last_k && int'(f_out) == last_f,
                $sformatf("R7 hold k=%0d f=%0d expected k=%0d f=%0d",
                          k_out, f_out, last_k, last_f));
        end
        n_in     = 16'(n);
        valid_in = v;
        pend_n   = n;
        pend_v   = v;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state
        chk(valid_out == 0 && k_out == 0 && f_out == 0 && zero_out == 0,
            $sformatf("R8 reset v=%0d k=%0d f=%0d zf=%0d expected all 0",
                      valid_out, k_out, f_out, zero_out));

        // Directed corners
        step(0, 1);
        step(1, 1);
        step(2, 1);
        step(3, 1);
        step(16'h8000, 1);
        step(16'hFFFF, 1);
        step(16'h7FFF, 1);
        // R5: piece and interval edges with an exact 13-bit fraction (k = 13)
        step(16'h2000, 1, "R5");
        step(16'h207F, 1, "R5");
        step(16'h2080, 1, "R5");
        step(16'h27FF, 1, "R5");
        step(16'h2800, 1, "R5");
        step(16'h2FFF, 1, "R5");
        step(16'h3000, 1, "R5");
        step(16'h37FF, 1, "R5");
        step(16'h3800, 1, "R5");
        step(16'h3FFF, 1, "R5");

        // R7: operand changes while valid_in is low must not reach the outputs
        step(16'h1234, 1);
        step(0, 0);
        step(16'hFFFF, 0);
        step(7, 0);
        step(5, 1);

        // R9: dropped low bits do not change the result
        step(16'hC000, 1);
        step(16'hC003, 1);
        step(0, 0);
        chk(last_k == prev_k && last_f == prev_f,
            $sformatf("R9 0xC003 gives k=%0d f=%0d expected k=%0d f=%0d",
                      last_k, last_f, prev_k, prev_f));
        step(16'h4000, 1);
        step(16'h4001, 1);
        step(0, 0);
        chk(last_k == prev_k && last_f == prev_f,
            $sformatf("R9 0x4001 gives k=%0d f=%0d expected k=%0d f=%0d",
                      last_k, last_f, prev_k, prev_f));

        // Exhaustive sweep of all operands
        for (int n = 0; n < 65536; n++) step(n, 1);

        // Random operands with random valid gaps
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            int rn;
            rn = int'($urandom() & 32'hFFFF);
            if (($urandom() & 32'h3) == 0) rn = rn >> ($urandom() % 16);
            step(rn, ($urandom() % 4) != 0);
        end
        step(0, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired after %0d cycles, expected completion", WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule